// File: doc/BRIEF.md
# Vector Multi-Structure Load/Store Decoder

This block takes one 32-bit instruction word from the vector "load/store multiple structures" class and turns it into a descriptor that an access sequencer can use. The descriptor holds the first data register, the base and offset registers, the element size, the 128-bit (quad) flag, the transfer direction and the post-index flag. It also holds the number of register passes (repeat) and the number of interleaved elements in each structure. Both counts come from the 4-bit opcode field.

The decode itself is combinational. Its result lands in a one-entry output slot, which is loaded on a valid/ready handshake. An illegal word does not produce a descriptor. It produces an undefined-instruction indication in the same slot, and the consumer accepts it through the same `out_ready` handshake. A word is accepted when `in_valid` and `in_ready` are both high at a rising clock edge. The result appears on the outputs after that edge. While the slot is full and the consumer also takes the current entry in that cycle, the block accepts a new word every cycle.

Top module: `vls_multi_decoder`

## Requirements
- R1: While reset is high and after it is released with no input, `out_valid` and `out_undef` are 0 and `in_ready` is 1.
- R2: For a legal word, the outputs carry these fields: `out_rt`=bits[4:0], `out_rn`=bits[9:5], `out_size`=bits[11:10], `out_rm`=bits[20:16], `out_load`=bit 22 (1 = load), `out_postidx`=bit 23 and `out_q`=bit 30.
- R3: The opcode in bits[15:12] maps to (repeat, elements) as follows: 0111→(1,1), 1010→(2,1), 0110→(3,1), 0010→(4,1), 1000→(1,2), 0100→(1,3), 0000→(1,4). Each count is a 3-bit binary value.
- R4: The nine other opcode values give `out_undef`=1 and `out_valid`=0.
- R5: A word whose bit 31 is 1, whose bit 21 is 1, or whose bits[29:24] differ from 001100 gives `out_undef`.
- R6: With bit 23 = 0, a nonzero bits[20:16] gives `out_undef`. With bit 23 = 1, any value of bits[20:16] is legal.
- R7: size 3 with bit 30 = 0 and an element count other than 1 gives `out_undef`. Size 3 with bit 30 = 1, or with an element count of 1, is legal.
- R8: `out_valid` and `out_undef` are never high in the same cycle.
- R9: A result appears in the cycle after its word is accepted. It stays unchanged while `out_ready` is low and leaves after a cycle in which `out_ready` is high. `in_ready` is high when the slot is empty or `out_ready` is high.
- R10: With `out_ready` held high, a word can be accepted on every cycle, so `in_ready` never drops.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Instruction word offered |
| in_ready | output | 1 | Decoder can take a word this cycle |
| in_insn | input | 32 | Instruction word |
| out_valid | output | 1 | Slot holds a legal descriptor |
| out_undef | output | 1 | Slot holds an undefined-instruction result |
| out_ready | input | 1 | Consumer takes the slot entry |
| out_rt | output | 5 | First data register |
| out_rn | output | 5 | Base register |
| out_rm | output | 5 | Post-index register field |
| out_size | output | 2 | Element size code |
| out_q | output | 1 | 128-bit register width |
| out_load | output | 1 | 1 = load, 0 = store |
| out_postidx | output | 1 | Base is written back after the access |
| out_rpt | output | 3 | Register pass count, 1..4 |
| out_selem | output | 3 | Elements per structure, 1..4 |

## Verification
The bench sends all sixteen opcodes. A swapped table entry would give wrong repeat or element counts, and an opcode that was not rejected would appear as a valid descriptor where an undef is expected. It probes the three reserved-form rules at their edges: Rm nonzero with and without post-index, and size 3 with each width and element count. A rule with the wrong polarity would reject a legal access or pass an illegal one. The same words are then replayed while `out_ready` is withheld on a regular pattern. A slot that changed, dropped or duplicated an entry under stall would break the in-order comparison or the stability check.

// File: rtl/vls_pkg.sv
package vls_pkg;
    localparam int INSN_W = 32;
    localparam int REG_W  = 5;
    localparam int SIZE_W = 2;
    localparam int OPC_W  = 4;
    localparam int CNT_W  = 3;
    localparam int CLS_W  = 6;
    localparam logic [CLS_W-1:0]  CLASS_PAT = 6'b001100;
    localparam logic [SIZE_W-1:0] SIZE_DBL  = 2'd3;

    typedef enum logic [OPC_W-1:0] {
        OPC_S4 = 4'b0000,
        OPC_R4 = 4'b0010,
        OPC_S3 = 4'b0100,
        OPC_R3 = 4'b0110,
        OPC_R1 = 4'b0111,
        OPC_S2 = 4'b1000,
        OPC_R2 = 4'b1010
    } vls_opc_e;

    typedef struct packed {
        logic [REG_W-1:0]  rt;
        logic [REG_W-1:0]  rn;
        logic [REG_W-1:0]  rm;
        logic [SIZE_W-1:0] size;
        logic              q;
        logic              load;
        logic              postidx;
        logic [CNT_W-1:0]  rpt;
        logic [CNT_W-1:0]  selem;
    } vls_desc_t;

    typedef struct packed {
        logic [CNT_W-1:0] rpt;
        logic [CNT_W-1:0] selem;
        logic             legal;
    } vls_shape_t;

    function automatic vls_shape_t mk_shape(input int r, input int s);
        vls_shape_t sh;
        sh.rpt   = CNT_W'(r);
        sh.selem = CNT_W'(s);
        sh.legal = 1'b1;
        return sh;
    endfunction
endpackage

// File: rtl/vls_opcode_map.sv
module vls_opcode_map
    import vls_pkg::*;
(
    input  logic [OPC_W-1:0] opc,
    output vls_shape_t       shape
);
    always_comb begin
        shape = '0;
        case (opc)
            OPC_R1:  shape = mk_shape(1, 1);
            OPC_R2:  shape = mk_shape(2, 1);
            OPC_R3:  shape = mk_shape(3, 1);
            OPC_R4:  shape = mk_shape(4, 1);
            OPC_S2:  shape = mk_shape(1, 2);
            OPC_S3:  shape = mk_shape(1, 3);
            OPC_S4:  shape = mk_shape(1, 4);
            default: shape = '0;
        endcase
    end
endmodule

// File: rtl/vls_field_decode.sv
module vls_field_decode
    import vls_pkg::*;
(
    input  logic [INSN_W-1:0] insn,
    output vls_desc_t         desc,
    output logic              undef
);
    vls_shape_t shape;
    logic       cls_ok;
    logic       rm_bad;
    logic       rsv_form;

    vls_opcode_map u_map (
        .opc   (insn[15:12]),
        .shape (shape)
    );

    always_comb begin
        desc.rt      = insn[4:0];
        desc.rn      = insn[9:5];
        desc.size    = insn[11:10];
        desc.rm      = insn[20:16];
        desc.load    = insn[22];
        desc.postidx = insn[23];
        desc.q       = insn[30];
        desc.rpt     = shape.rpt;
        desc.selem   = shape.selem;
    end

    assign cls_ok   = !insn[31] && !insn[21] && (insn[29:24] == CLASS_PAT);
    assign rm_bad   = !desc.postidx && (desc.rm != '0);
    assign rsv_form = (desc.size == SIZE_DBL) && !desc.q && (shape.selem != CNT_W'(1));
    assign undef    = !cls_ok || !shape.legal || rm_bad || rsv_form;
endmodule

// File: rtl/vls_out_stage.sv
module vls_out_stage
    import vls_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      in_valid,
    output logic      in_ready,
    input  vls_desc_t desc_in,
    input  logic      undef_in,
    input  logic      out_ready,
    output logic      out_valid,
    output logic      out_undef,
    output vls_desc_t desc_out
);
    logic      full_q;
    logic      undef_q;
    vls_desc_t desc_q;
    logic      take;

    assign in_ready = !full_q || out_ready;
    assign take     = in_valid && in_ready;

    always_ff @(posedge clk) begin
        if (rst) begin
            full_q  <= 1'b0;
            undef_q <= 1'b0;
            desc_q  <= '0;
        end else if (take) begin
            full_q  <= 1'b1;
            undef_q <= undef_in;
            desc_q  <= desc_in;
        end else if (out_ready) begin
            full_q  <= 1'b0;
        end
    end

    assign out_valid = full_q && !undef_q;
    assign out_undef = full_q && undef_q;
    assign desc_out  = desc_q;

    // R8
    p_excl_r8: assert property (@(posedge clk) disable iff (rst)
        !(out_valid && out_undef));
    // R9
    p_accept_r9: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_ready) |=> (out_valid || out_undef));
    p_hold_r9: assert property (@(posedge clk) disable iff (rst)
        ((out_valid || out_undef) && !out_ready) |=>
        ($stable(out_valid) && $stable(out_undef) && $stable(desc_out)));
    p_drain_r9: assert property (@(posedge clk) disable iff (rst)
        ((out_valid || out_undef) && out_ready && !in_valid) |=> !(out_valid || out_undef));
    // R3
    p_shape_r3: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> (desc_out.rpt >= 3'd1 && desc_out.rpt <= 3'd4 &&
                       desc_out.selem >= 3'd1 && desc_out.selem <= 3'd4 &&
                       (desc_out.rpt == 3'd1 || desc_out.selem == 3'd1)));
    // R6
    p_rm_zero_r6: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !desc_out.postidx) |-> (desc_out.rm == '0));
    // R7
    p_rsv_r7: assert property (@(posedge clk) disable iff (rst)
        (out_valid && desc_out.size == SIZE_DBL && !desc_out.q) |-> (desc_out.selem == 3'd1));
endmodule

// File: rtl/vls_multi_decoder.sv
module vls_multi_decoder
    import vls_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [INSN_W-1:0] in_insn,
    output logic              out_valid,
    output logic              out_undef,
    input  logic              out_ready,
    output logic [REG_W-1:0]  out_rt,
    output logic [REG_W-1:0]  out_rn,
    output logic [REG_W-1:0]  out_rm,
    output logic [SIZE_W-1:0] out_size,
    output logic              out_q,
    output logic              out_load,
    output logic              out_postidx,
    output logic [CNT_W-1:0]  out_rpt,
    output logic [CNT_W-1:0]  out_selem
);
    vls_desc_t dec_desc;
    vls_desc_t held;
    logic      dec_undef;

    vls_field_decode u_dec (
        .insn  (in_insn),
        .desc  (dec_desc),
        .undef (dec_undef)
    );

    vls_out_stage u_stage (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (in_valid),
        .in_ready  (in_ready),
        .desc_in   (dec_desc),
        .undef_in  (dec_undef),
        .out_ready (out_ready),
        .out_valid (out_valid),
        .out_undef (out_undef),
        .desc_out  (held)
    );

    assign out_rt      = held.rt;
    assign out_rn      = held.rn;
    assign out_rm      = held.rm;
    assign out_size    = held.size;
    assign out_q       = held.q;
    assign out_load    = held.load;
    assign out_postidx = held.postidx;
    assign out_rpt     = held.rpt;
    assign out_selem   = held.selem;

    // R1
    p_idle_after_reset_r1: assert property (@(posedge clk)
        rst |=> (!out_valid && !out_undef));
endmodule

// File: tb/vls_multi_decoder_bench.sv
`timescale 1ns/1ps
module vls_multi_decoder_bench;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic        in_ready;
    logic [31:0] in_insn = '0;
    logic        out_valid, out_undef;
    logic        out_ready = 1'b0;
    logic [4:0]  out_rt, out_rn, out_rm;
    logic [1:0]  out_size;
    logic        out_q, out_load, out_postidx;
    logic [2:0]  out_rpt, out_selem;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;
    bit stall_mode = 1'b0;
    int free_stalls = 0;
    int rdy_cyc = 0;

    typedef struct {
        bit          undef;
        logic [25:0] f;
        string       req;
    } exp_t;
    exp_t sb_q[$];

    logic [25:0] cur_f;
    assign cur_f = {out_rt, out_rn, out_rm, out_size, out_q, out_load, out_postidx, out_rpt, out_selem};

    always #10 clk = ~clk;

    vls_multi_decoder u_vls_multi_decoder (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready), .in_insn(in_insn),
        .out_valid(out_valid), .out_undef(out_undef), .out_ready(out_ready),
        .out_rt(out_rt), .out_rn(out_rn), .out_rm(out_rm), .out_size(out_size), .out_q(out_q),
        .out_load(out_load), .out_postidx(out_postidx), .out_rpt(out_rpt), .out_selem(out_selem)
    );

    function automatic logic [31:0] mk(input bit q, input bit ld, input bit p, input logic [4:0] rm,
                                       input logic [3:0] opc, input logic [1:0] sz,
                                       input logic [4:0] rn, input logic [4:0] rt);
        return {1'b0, q, 6'b001100, p, ld, 1'b0, rm, opc, sz, rn, rt};
    endfunction

    function automatic exp_t model(input logic [31:0] w, input string req);
        exp_t e;
        int r = 0;
        int s = 0;
        bit bad;
        case (w[15:12])
            4'h7: begin r = 1; s = 1; end
            4'hA: begin r = 2; s = 1; end
            4'h6: begin r = 3; s = 1; end
            4'h2: begin r = 4; s = 1; end
            4'h8: begin r = 1; s = 2; end
            4'h4: begin r = 1; s = 3; end
            4'h0: begin r = 1; s = 4; end
            default: begin r = 0; s = 0; end
        endcase
        bad = (r == 0) || w[31] || w[21] || (w[29:24] != 6'b001100) ||
              (!w[23] && (w[20:16] != 5'd0)) ||
              ((w[11:10] == 2'd3) && !w[30] && (s != 1));
        e.undef = bad;
        e.req   = req;
        e.f     = {w[4:0], w[9:5], w[20:16], w[11:10], w[30], w[22], w[23], 3'(r), 3'(s)};
        return e;
    endfunction

    task automatic check(input bit ok, input string req, input string what);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: %s", req, what);
        end
    endtask

    task automatic send(input logic [31:0] w, input string req);
        @(negedge clk);
        in_valid = 1'b1;
        in_insn  = w;
        if (!in_ready && !stall_mode) free_stalls++;
        while (!in_ready) @(negedge clk);
        sb_q.push_back(model(w, req));
    endtask

    // consumer readiness, changed just after each rising edge
    initial begin
        forever begin
            @(posedge clk);
            #1;
            rdy_cyc++;
            out_ready = stall_mode ? ((rdy_cyc % 3) != 0) : 1'b1;
        end
    end

    // monitor / scoreboard
    bit          prev_hold = 1'b0;
    logic        pv, pu;
    logic [25:0] pf;
    always @(negedge clk) begin
        if (!rst && !done) begin
            if (prev_hold)
                check(out_valid === pv && out_undef === pu && cur_f === pf, "R9",
                      $sformatf("held entry changed: v=%0b u=%0b f=%h, expected v=%0b u=%0b f=%h",
                                out_valid, out_undef, cur_f, pv, pu, pf));
            if ((out_valid || out_undef) && out_ready) begin
                if (sb_q.size() == 0) begin
                    check(1'b0, "R9", $sformatf("unexpected entry v=%0b u=%0b, expected none",
                                                out_valid, out_undef));
                end else begin
                    exp_t e;
                    e = sb_q.pop_front();
                    if (e.undef)
                        check(out_undef && !out_valid, e.req,
                              $sformatf("got v=%0b u=%0b, expected v=0 u=1", out_valid, out_undef));
                    else
                        check(out_valid && !out_undef && cur_f === e.f, e.req,
                              $sformatf("got v=%0b u=%0b f=%h, expected v=1 u=0 f=%h",
                                        out_valid, out_undef, cur_f, e.f));
                end
            end
            prev_hold = (out_valid || out_undef) && !out_ready;
            pv = out_valid;
            pu = out_undef;
            pf = cur_f;
        end
    end

    task automatic run_set();
        // R2 R3: every legal opcode, varied fields
        send(mk(1, 1, 0, 5'd0,  4'h7, 2'd0, 5'd3,  5'd17), "R3");
        send(mk(0, 0, 1, 5'd31, 4'hA, 2'd1, 5'd31, 5'd30), "R3");
        send(mk(1, 1, 1, 5'd9,  4'h6, 2'd2, 5'd12, 5'd0),  "R3");
        send(mk(0, 1, 0, 5'd0,  4'h2, 2'd0, 5'd1,  5'd31), "R3");
        send(mk(1, 0, 0, 5'd0,  4'h8, 2'd3, 5'd20, 5'd5),  "R3");
        send(mk(0, 0, 1, 5'd2,  4'h4, 2'd2, 5'd7,  5'd11), "R3");
        send(mk(1, 1, 0, 5'd0,  4'h0, 2'd1, 5'd16, 5'd28), "R3");
        send(mk(1, 0, 1, 5'd21, 4'h7, 2'd2, 5'd10, 5'd21), "R2");
        // R4: unallocated opcodes
        for (int o = 0; o < 16; o++) begin
            if (!(o inside {0, 2, 4, 6, 7, 8, 10}))
                send(mk(1, 1, 1, 5'd4, 4'(o), 2'd0, 5'd2, 5'd3), "R4");
        end
        // R5: fixed bits
        send(mk(1, 1, 0, 5'd0, 4'h7, 2'd0, 5'd1, 5'd1) | 32'h8000_0000, "R5");
        send(mk(1, 1, 0, 5'd0, 4'h7, 2'd0, 5'd1, 5'd1) | 32'h0020_0000, "R5");
        send(mk(1, 1, 0, 5'd0, 4'h7, 2'd0, 5'd1, 5'd1) ^ 32'h0100_0000, "R5");
        send(mk(1, 1, 0, 5'd0, 4'h7, 2'd0, 5'd1, 5'd1) ^ 32'h2000_0000, "R5");
        // R6: offset field rule
        send(mk(1, 0, 0, 5'd5, 4'h7, 2'd0, 5'd1, 5'd2), "R6");
        send(mk(1, 0, 0, 5'd16, 4'h2, 2'd1, 5'd1, 5'd2), "R6");
        send(mk(1, 0, 1, 5'd5, 4'h7, 2'd0, 5'd1, 5'd2), "R6");
        send(mk(1, 0, 0, 5'd0, 4'h7, 2'd0, 5'd1, 5'd2), "R6");
        // R7: reserved size/width/element combination
        send(mk(0, 1, 0, 5'd0, 4'h0, 2'd3, 5'd4, 5'd6), "R7");
        send(mk(0, 1, 0, 5'd0, 4'h8, 2'd3, 5'd4, 5'd6), "R7");
        send(mk(1, 1, 0, 5'd0, 4'h0, 2'd3, 5'd4, 5'd6), "R7");
        send(mk(0, 1, 0, 5'd0, 4'h2, 2'd3, 5'd4, 5'd6), "R7");
        send(mk(0, 1, 0, 5'd0, 4'h4, 2'd2, 5'd4, 5'd6), "R7");
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        check(!out_valid && !out_undef && in_ready, "R1",
              $sformatf("in reset v=%0b u=%0b rdy=%0b, expected 0 0 1", out_valid, out_undef, in_ready));
        rst = 1'b0;
        @(negedge clk);
        check(!out_valid && !out_undef && in_ready, "R1",
              $sformatf("after reset v=%0b u=%0b rdy=%0b, expected 0 0 1", out_valid, out_undef, in_ready));

        run_set();
        check(free_stalls == 0, "R10",
              $sformatf("in_ready dropped %0d times with out_ready high, expected 0", free_stalls));

        stall_mode = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
        repeat (2) @(negedge clk);
        run_set();
        @(negedge clk);
        in_valid = 1'b0;
        stall_mode = 1'b0;
        for (int i = 0; i < 50 && sb_q.size() != 0; i++) @(negedge clk);
        repeat (2) @(negedge clk);
        check(sb_q.size() == 0, "R9",
              $sformatf("%0d results missing, expected 0", sb_q.size()));
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_chk++;
            n_bad++;
            $display("FAIL R9: watchdog expired with %0d results pending, expected 0", sb_q.size());
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule